// File: doc/BRIEF.md
# 16-bit packet bus receiver with flow control

This block receives packets from a 16-bit data bus carrying a 3-bit status code on every clock. It finds packet boundaries from the way the status code changes from one cycle to the next. It turns the bus traffic into a stream of 16-bit beats, and each beat carries start, end, byte-count and error flags for a downstream FIFO. The end of a packet is only known when the code drops back to idle. For that reason the most recent data beat waits in a one-beat hold register until the next code shows whether it was the last beat.

A small skid FIFO sits between the decoder and the output, and it has its own ready/valid handshake. The block drives a pause signal back to the sender in three cases: the count of free receive descriptors falls below a programmable low mark, software asks for a pause, or the skid FIFO fills to the point where only the pause latency is left. The sender may keep sending for a few cycles after the pause appears, so the FIFO keeps enough free room for those beats.

Fragments that begin without a proper start are discarded. Each one increments a counter.

Top module: `pkt16_rx`

## Requirements
- R1: After reset, out_valid is 0, fc_out is 0 (with desc_avail not below low_mark and sw_pause low) and orphan_cnt is 0.
- R2: Code 3'b101 received while idle starts a packet. The first output beat has out_sop=1 and out_two=1, and its data is rx_dat of that cycle.
- R3: Each further 3'b101 cycle inside a packet gives one beat with out_sop=0, out_eop=0 and out_two=1. Beats leave in arrival order.
- R4: Code 3'b001 inside a packet carries a final single byte, and the following 3'b000 ends the packet. The last beat has out_eop=1 and out_two=0, with the byte in out_data[7:0] and out_data[15:8] forced to 0.
- R5: Code 3'b101 followed by 3'b000 ends the packet on a two-byte beat: out_eop=1 and out_two=1.
- R6: Inside a packet, a code with bit 0 clear and bit 2 set (3'b100 or 3'b110) is a hold cycle. It produces no beat and does not end the packet.
- R7: A code with bit 1 set inside a packet (for example 3'b111, where bit 1 stays set until 3'b000) sets out_err=1 on that packet's end beat. All other beats, and the next clean packet, have out_err=0.
- R8: While idle, a code with bit 0 set that is not 3'b101 opens a fragment. The fragment produces no beats until 3'b000, and each fragment adds exactly 1 to orphan_cnt.
- R9: fc_out is 1 one clock after any of these holds: desc_avail < low_mark, sw_pause = 1, or FIFO fill level >= DEPTH-SKID. Otherwise it is 0.
- R10: With out_ready low, a sender that sends 4 more beats after seeing fc_out loses none of them. Every beat later comes out in order.
- R11: While out_valid=1 and out_ready=0, the output beat holds steady and no beat is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_ctl | input | 3 | Bus status code |
| rx_dat | input | 16 | Bus data, low byte in [7:0] |
| desc_avail | input | CW | Count of free receive descriptors |
| low_mark | input | CW | Descriptor low mark |
| sw_pause | input | 1 | Software pause request |
| out_ready | input | 1 | Downstream accepts a beat |
| out_valid | output | 1 | Output beat present |
| out_data | output | 16 | Beat data |
| out_sop | output | 1 | First beat of packet |
| out_eop | output | 1 | Last beat of packet |
| out_two | output | 1 | 1: both bytes valid, 0: low byte only |
| out_err | output | 1 | Packet received with error (end beat) |
| fc_out | output | 1 | Pause request toward the sender |
| orphan_cnt | output | OCW | Count of dropped fragments |

## Verification
A wrong decoder state shows up at the ports within two clocks of the code that exposes it. If the state is stuck idle, a packet's beats are missing and orphan_cnt is wrong. If the state is stuck in a packet, the next packet's first beat comes out without out_sop. A stale hold register shows up as a duplicated beat or a misplaced out_eop when the closing idle code arrives. A wrong FIFO pointer or fill level appears as reordered or missing beats once out_ready rises, or as fc_out asserting a clock late or never.

// File: rtl/pkt16_rx_pkg.sv
package pkt16_rx_pkg;

   localparam int DW = 16;

   typedef struct packed {
      logic [DW-1:0] data;
      logic          sop;
      logic          eop;
      logic          two;
      logic          err;
   } beat_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PKT  = 2'd1,
      ST_DROP = 2'd2
   } rx_state_t;

   localparam logic [2:0] C_IDLE = 3'b000;
   localparam logic [2:0] C_FULL = 3'b101;

endpackage

// File: rtl/pkt16_rx_decode.sv
module pkt16_rx_decode
   import pkt16_rx_pkg::*;
#(
   parameter int OCW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2:0]     ctl,
   input  logic [DW-1:0]  dat,
   output logic           push,
   output beat_t          push_beat,
   output logic [OCW-1:0] orphan_cnt
);

   rx_state_t st;
   beat_t     hold;
   logic      err_q;
   logic      in_pkt;
   logic      is_idle;

   assign in_pkt  = (st == ST_PKT);
   assign is_idle = (ctl == C_IDLE);

   // the held beat leaves when a new data beat or the closing idle arrives
   assign push = in_pkt && (ctl[0] || is_idle);

   always_comb begin
      push_beat     = hold;
      push_beat.eop = is_idle;
      push_beat.err = is_idle && err_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         hold       <= '0;
         err_q      <= 1'b0;
         orphan_cnt <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (ctl == C_FULL) begin
                  hold  <= '{data: dat, sop: 1'b1, eop: 1'b0, two: 1'b1, err: 1'b0};
                  err_q <= 1'b0;
                  st    <= ST_PKT;
               end else if (ctl[0]) begin
                  st         <= ST_DROP;
                  orphan_cnt <= orphan_cnt + 1'b1;
               end
            end
            ST_PKT: begin
               if (is_idle) begin
                  st    <= ST_IDLE;
                  err_q <= 1'b0;
               end else begin
                  if (ctl[1]) err_q <= 1'b1;
                  if (ctl[0]) begin
                     hold.data <= ctl[2] ? dat : {8'h00, dat[7:0]};
                     hold.sop  <= 1'b0;
                     hold.eop  <= 1'b0;
                     hold.two  <= ctl[2];
                     hold.err  <= 1'b0;
                  end
               end
            end
            ST_DROP: begin
               if (is_idle) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pkt16_rx_skid.sv
module pkt16_rx_skid #(
   parameter int W     = 20,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] din,
   input  logic         rd_en,
   output logic [W-1:0] dout,
   output logic         valid,
   output logic         full,
   output logic [AW:0]  level
);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;
   logic         do_wr, do_rd;

   assign level = wp - rp;
   assign full  = (level == (AW+1)'(DEPTH));
   assign valid = (level != '0);
   assign dout  = mem[rp[AW-1:0]];
   assign do_wr = wr_en && !full;
   assign do_rd = rd_en && valid;

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp[AW-1:0]] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (do_wr) wp <= wp + 1'b1;
         if (do_rd) rp <= rp + 1'b1;
      end
   end

endmodule

// File: rtl/pkt16_rx_fc.sv
module pkt16_rx_fc #(
   parameter int CW     = 8,
   parameter int LW     = 5,
   parameter int THRESH = 8,
   parameter bit REG_FC = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] desc_avail,
   input  logic [CW-1:0] low_mark,
   input  logic          sw_pause,
   input  logic [LW-1:0] level,
   output logic          fc_out
);

   logic fc_raw;

   assign fc_raw = (desc_avail < low_mark) || sw_pause
                   || (level >= LW'(THRESH));

   generate
      if (REG_FC) begin : g_reg
         logic fc_q;
         always_ff @(posedge clk) begin
            if (!rst_n) fc_q <= 1'b0;
            else        fc_q <= fc_raw;
         end
         assign fc_out = fc_q;
      end else begin : g_comb
         assign fc_out = fc_raw;
      end
   endgenerate

endmodule

// File: rtl/pkt16_rx.sv
module pkt16_rx
   import pkt16_rx_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int SKID   = 8,
   parameter int CW     = 8,
   parameter int OCW    = 8,
   parameter bit REG_FC = 1'b1,
   localparam int LW    = $clog2(DEPTH) + 1,
   localparam int BW    = $bits(beat_t)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2:0]     rx_ctl,
   input  logic [15:0]    rx_dat,
   input  logic [CW-1:0]  desc_avail,
   input  logic [CW-1:0]  low_mark,
   input  logic           sw_pause,
   input  logic           out_ready,
   output logic           out_valid,
   output logic [15:0]    out_data,
   output logic           out_sop,
   output logic           out_eop,
   output logic           out_two,
   output logic           out_err,
   output logic           fc_out,
   output logic [OCW-1:0] orphan_cnt
);

   generate
      if (SKID < 6) begin : g_bad_skid
         $error("SKID must cover at least 6 beats of pause latency");
      end
      if (SKID >= DEPTH) begin : g_bad_depth
         $error("DEPTH must exceed SKID");
      end
      if ((1 << $clog2(DEPTH)) != DEPTH) begin : g_bad_pow2
         $error("DEPTH must be a power of two");
      end
   endgenerate

   logic          push_w;
   logic          full_w;
   beat_t         push_beat;
   beat_t         head;
   logic [BW-1:0] head_bits;
   logic [LW-1:0] level_w;

   pkt16_rx_decode #(.OCW(OCW)) dec_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl        (rx_ctl),
      .dat        (rx_dat),
      .push       (push_w),
      .push_beat  (push_beat),
      .orphan_cnt (orphan_cnt)
   );

   pkt16_rx_skid #(.W(BW), .DEPTH(DEPTH)) skid_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (push_w),
      .din   (push_beat),
      .rd_en (out_ready),
      .dout  (head_bits),
      .valid (out_valid),
      .full  (full_w),
      .level (level_w)
   );

   pkt16_rx_fc #(.CW(CW), .LW(LW), .THRESH(DEPTH - SKID), .REG_FC(REG_FC)) fc_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .desc_avail (desc_avail),
      .low_mark   (low_mark),
      .sw_pause   (sw_pause),
      .level      (level_w),
      .fc_out     (fc_out)
   );

   assign head     = beat_t'(head_bits);
   assign out_data = head.data;
   assign out_sop  = head.sop;
   assign out_eop  = head.eop;
   assign out_two  = head.two;
   assign out_err  = head.err;

endmodule

// File: rtl/pkt16_rx_chk.sv
module pkt16_rx_chk #(
   parameter int CW     = 8,
   parameter int OCW    = 8,
   parameter bit REG_FC = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic [CW-1:0]  desc_avail,
   input logic [CW-1:0]  low_mark,
   input logic           sw_pause,
   input logic           fc_out,
   input logic           out_valid,
   input logic           out_ready,
   input logic [15:0]    out_data,
   input logic           out_sop,
   input logic           out_eop,
   input logic [OCW-1:0] orphan_cnt,
   input logic           push,
   input logic           full
);

   logic mid_pkt;
   logic take;

   assign take = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n)    mid_pkt <= 1'b0;
      else if (take) mid_pkt <= !out_eop;
   end

   // R2: a beat accepted between packets must open one
   p_first_sop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !mid_pkt) |-> out_sop);

   // R3: no start flag once a packet is under way
   p_no_mid_sop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (take && mid_pkt) |-> !out_sop);

   // R8: the fragment counter moves by one step at a time
   p_orphan_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (orphan_cnt != $past(orphan_cnt)) |-> (orphan_cnt == $past(orphan_cnt) + 1'b1));

   // R10: the decoder never writes into a full skid store
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full));

   // R11: a stalled beat stays put
   p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)
                                     && $stable(out_eop)));

   generate
      if (REG_FC) begin : g_fc_chk
         // R9: descriptor shortage or software request raises the pause next clock
         p_fc_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ((desc_avail < low_mark) || sw_pause) |=> fc_out);
      end
   endgenerate

endmodule

bind pkt16_rx pkt16_rx_chk #(.CW(CW), .OCW(OCW), .REG_FC(REG_FC)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .desc_avail (desc_avail),
   .low_mark   (low_mark),
   .sw_pause   (sw_pause),
   .fc_out     (fc_out),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_data   (out_data),
   .out_sop    (out_sop),
   .out_eop    (out_eop),
   .orphan_cnt (orphan_cnt),
   .push       (push_w),
   .full       (full_w)
);

// File: tb/pkt16_rx_tb_top.sv
module pkt16_rx_tb_top;

   localparam int CLK_P = 10;

   typedef struct packed {
      logic [15:0] d;
      logic sop, eop, two, err;
   } xb_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  rx_ctl = 3'b000;
   logic [15:0] rx_dat = '0;
   logic [7:0]  desc_avail = 8'd20;
   logic [7:0]  low_mark = 8'd4;
   logic        sw_pause = 1'b0;
   logic        out_ready = 1'b1;
   logic        out_valid, out_sop, out_eop, out_two, out_err, fc_out;
   logic [15:0] out_data;
   logic [7:0]  orphan_cnt;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 1'b0;
   xb_t exp_q[$];
   xb_t got_q[$];

   always #(CLK_P/2) clk = ~clk;

   pkt16_rx dut_i (
      .clk(clk), .rst_n(rst_n), .rx_ctl(rx_ctl), .rx_dat(rx_dat),
      .desc_avail(desc_avail), .low_mark(low_mark), .sw_pause(sw_pause),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop), .out_two(out_two), .out_err(out_err),
      .fc_out(fc_out), .orphan_cnt(orphan_cnt)
   );

   // beat monitor, sampling well after the edge
   always begin
      @(posedge clk);
      #7;
      if (rst_n && out_valid && out_ready)
         got_q.push_back('{d: out_data, sop: out_sop, eop: out_eop, two: out_two, err: out_err});
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] c, input logic [15:0] d);
      @(negedge clk);
      rx_ctl = c;
      rx_dat = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(3'b000, 16'h0);
   endtask

   // one packet of n bytes; err_b/gap_b = beat index or -1
   task automatic send_pkt(input int n, input logic [7:0] base, input int err_b, input int gap_b);
      int nb = (n + 1) / 2;
      for (int b = 0; b < nb; b++) begin
         logic       two = (2*b + 1) < n;
         logic       e   = (err_b >= 0) && (b >= err_b);
         logic [7:0] lo  = base + 8'(2*b);
         logic [7:0] hi  = two ? base + 8'(2*b + 1) : 8'hEE;
         drive({two, e, 1'b1}, {hi, lo});
         exp_q.push_back('{d: {two ? hi : 8'h00, lo}, sop: (b == 0), eop: (b == nb-1),
                           two: two, err: (b == nb-1) && (err_b >= 0)});
         if (b == gap_b) drive({1'b1, e, 1'b0}, 16'hDEAD);
      end
      drive(3'b000, 16'h0);
   endtask

   task automatic compare(input string req);
      idle(6);
      check(got_q.size() == exp_q.size(), req, "beat count", got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
         string t = exp_q[i].sop ? "R2" : exp_q[i].err ? "R7" :
                    exp_q[i].eop ? (exp_q[i].two ? "R5" : "R4") : "R3";
         check(got_q[i] == exp_q[i], t, $sformatf("%s beat %0d", req, i), got_q[i], exp_q[i]);
      end
      exp_q.delete();
      got_q.delete();
   endtask

   task automatic t_reset();
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(fc_out == 1'b0, "R1", "fc_out after reset", fc_out, 0);
      check(orphan_cnt == 8'd0, "R1", "orphan_cnt after reset", orphan_cnt, 0);
   endtask

   task automatic t_even();
      send_pkt(6, 8'h10, -1, -1);
      compare("R5 even packet");
   endtask

   task automatic t_odd();
      send_pkt(5, 8'h40, -1, -1);
      compare("R4 odd packet");
   endtask

   task automatic t_back_to_back();
      send_pkt(4, 8'h60, -1, -1);
      send_pkt(3, 8'h70, -1, -1);
      compare("R3 back to back");
   endtask

   task automatic t_gap();
      send_pkt(8, 8'h80, -1, 1);
      compare("R6 hold cycle");
   endtask

   task automatic t_err();
      send_pkt(7, 8'hA0, 1, -1);
      send_pkt(4, 8'hB0, -1, -1);
      compare("R7 error packet");
   endtask

   task automatic t_orphan();
      logic [7:0] c0 = orphan_cnt;
      drive(3'b001, 16'h1111);
      drive(3'b101, 16'h2222);
      drive(3'b101, 16'h3333);
      drive(3'b000, 16'h0);
      drive(3'b111, 16'h4444);
      drive(3'b000, 16'h0);
      idle(4);
      check(got_q.size() == 0, "R8", "fragment beats", got_q.size(), 0);
      check(orphan_cnt == c0 + 8'd2, "R8", "orphan_cnt after 2 fragments", orphan_cnt, c0 + 8'd2);
      send_pkt(2, 8'hC0, -1, -1);
      compare("R8 packet after fragments");
   endtask

   task automatic t_fc();
      @(negedge clk) desc_avail = 8'd3;
      @(negedge clk);
      check(fc_out == 1'b1, "R9", "fc on low descriptors", fc_out, 1);
      desc_avail = 8'd4;
      @(negedge clk);
      check(fc_out == 1'b0, "R9", "fc at mark", fc_out, 0);
      sw_pause = 1'b1;
      @(negedge clk);
      check(fc_out == 1'b1, "R9", "fc on sw pause", fc_out, 1);
      sw_pause = 1'b0;
      desc_avail = 8'd20;
      @(negedge clk);
      check(fc_out == 1'b0, "R9", "fc released", fc_out, 0);
   endtask

   task automatic t_skid();
      int   extra = -1;
      int   b = 0;
      logic [15:0] d0;
      out_ready = 1'b0;
      while (extra != 0 && b < 24) begin
         logic [15:0] d = {8'(2*b + 1), 8'(2*b)} ^ 16'h5A00;
         drive(3'b101, d);
         exp_q.push_back('{d: d, sop: (b == 0), eop: 1'b0, two: 1'b1, err: 1'b0});
         b++;
         if (extra > 0) extra--;
         else if (extra < 0 && fc_out) extra = 4;
      end
      check(extra == 0, "R9", "fc raised by fill level", extra, 0);
      exp_q[exp_q.size()-1].eop = 1'b1;
      drive(3'b000, 16'h0);
      idle(2);
      d0 = out_data;
      idle(2);
      check(out_valid && out_data == d0, "R11", "stalled beat steady", out_data, d0);
      check(got_q.size() == 0, "R11", "nothing taken while stalled", got_q.size(), 0);
      @(negedge clk) out_ready = 1'b1;
      idle(24);
      compare("R10 skid after pause");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_even();
      t_odd();
      t_back_to_back();
      t_gap();
      t_err();
      t_orphan();
      t_fc();
      t_skid();
      finish_run();
   end

endmodule